// File: doc/BRIEF.md
# Serial Audio Word Receiver with Width Adaptation

This block takes a three-wire serial audio stream (bit clock, word select, serial data) and recovers the left and right channel samples from it. The three lines are brought into the system clock domain through a synchroniser. Each rising edge of the bit clock is detected there, and the word-select and data levels are captured on that edge.

The receiver's sample width is a fixed build parameter. The sender's word length is not known in advance and may be any number of bits. Each received word is placed into the receiver width left-aligned:

- A word shorter than the width gets zeros in the low-order bits it lacks.
- A word longer than the width loses its trailing low-order bits.

A change on word select closes the word in progress. The finished sample is then shown for one system clock with a strobe and a flag that gives its channel. The stream carries audio samples only, with no control fields.

Top module: `serial_audio_rx`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, smp_vld_o is 0, smp_data_o is all zeros and smp_chan_o is 0.
- R2: Data is captured on rising edges of aud_sck_i, most significant bit first. The first bit of a word is the one captured on the rising edge that follows the edge where a word-select change is first seen.
- R3: The bit captured on the edge where a word-select change is seen is the last bit of the word that is ending. That word is then output with smp_vld_o high for exactly one clock. smp_chan_o gives the word's channel: 0 means word select was low (left) and 1 means high (right). Exactly one strobe is produced per word completed after the first change.
- R4: A word of L bits with L below SAMPLE_W is output as the word shifted left by SAMPLE_W-L, so the low bits are zero.
- R5: A word of L bits with L above SAMPLE_W is output as its first SAMPLE_W bits, which is the word shifted right by L-SAMPLE_W. The bit count stops at SAMPLE_W, so later bits do not change the bits already stored.
- R6: A word of exactly SAMPLE_W bits is output unchanged.
- R7: After reset, the word that ends at the first word-select change is discarded and produces no strobe. A reset in the middle of a word drops the partial word.
- R8: smp_data_o and smp_chan_o keep their values in every cycle in which smp_vld_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| aud_sck_i | input | 1 | Serial bit clock, asynchronous to clk_i |
| aud_ws_i | input | 1 | Word select: 0 left, 1 right |
| aud_sd_i | input | 1 | Serial data, MSB first |
| smp_data_o | output | SAMPLE_W | Left-aligned received sample |
| smp_chan_o | output | 1 | Channel of the presented sample (0 left, 1 right) |
| smp_vld_o | output | 1 | One-cycle strobe for a new sample |

## Verification
On the bit-clock edge that carries a word's last bit, capturing that bit and closing the word happen together. The sample that is output must therefore already contain that bit, while the next word must start from zero. The bench sweeps sender word lengths from 1 to 12 against an 8-bit receiver with alternating channels, so this coincidence occurs on every word. It covers the shortest word, where the first and last bit share one slot, and words long enough that the last bit falls past the saturated counter. Every strobed sample is compared with the arithmetically shifted value the bench expects, and its channel flag is checked against the channel the bench sent.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  typedef struct packed {
    logic  stb;   // bit clock rising edge seen
    logic  bit_v; // data bit captured on that edge
    logic  fin;   // word select changed on that edge
    chan_e chan;  // channel of the word that finishes
  } slot_evt_t;
endpackage

// File: rtl/serial_audio_rx_sync.sv
module serial_audio_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/serial_audio_rx_slot.sv
module serial_audio_rx_slot
  import serial_audio_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sck_i,
  input  logic      ws_i,
  input  logic      sd_i,
  output slot_evt_t evt_o
);
  logic sck_q, ws_q, primed_q;
  logic rise;

  assign rise = sck_i & ~sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      ws_q     <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      sck_q <= sck_i;
      if (rise) begin
        ws_q     <= ws_i;
        primed_q <= 1'b1;
      end
    end
  end

  always_comb begin
    evt_o.stb   = rise;
    evt_o.bit_v = sd_i;
    // first edge after reset only learns the current word-select level
    evt_o.fin   = rise & primed_q & (ws_i != ws_q);
    evt_o.chan  = chan_e'(ws_q);
  end

  // R2
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.stb |=> !evt_o.stb);

  // R3
  fin_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.fin |=> (ws_q != $past(ws_q)));
endmodule

// File: rtl/serial_audio_rx_pack.sv
module serial_audio_rx_pack
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  slot_evt_t           evt_i,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                chan_o,
  output logic                vld_o
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] acc_q, acc_nxt;
  logic [CNT_W-1:0]    cnt_q;
  logic                started_q;

  // place the incoming bit at its MSB-first position; dropped once full
  always_comb begin
    acc_nxt = acc_q;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (cnt_q == CNT_W'(SAMPLE_W - 1 - i)) acc_nxt[i] = evt_i.bit_v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
      data_o    <= '0;
      chan_o    <= 1'b0;
      vld_o     <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (evt_i.stb) begin
        if (evt_i.fin) begin
          if (started_q) begin
            data_o <= acc_nxt;
            chan_o <= evt_i.chan;
            vld_o  <= 1'b1;
          end
          started_q <= 1'b1;
          acc_q     <= '0;
          cnt_q     <= '0;
        end else begin
          acc_q <= acc_nxt;
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  // R3
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> ($stable(data_o) && $stable(chan_o)));

  // R7
  first_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> started_q);
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                aud_sck_i,
  input  logic                aud_ws_i,
  input  logic                aud_sd_i,
  output logic [SAMPLE_W-1:0] smp_data_o,
  output logic                smp_chan_o,
  output logic                smp_vld_o
);
  localparam int LINES = 3;

  logic [LINES-1:0] lines_s;
  slot_evt_t        evt;

  serial_audio_rx_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (LINES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({aud_sck_i, aud_ws_i, aud_sd_i}),
    .sync_o  (lines_s)
  );

  serial_audio_rx_slot u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (lines_s[2]),
    .ws_i   (lines_s[1]),
    .sd_i   (lines_s[0]),
    .evt_o  (evt)
  );

  serial_audio_rx_pack #(
    .SAMPLE_W (SAMPLE_W)
  ) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .data_o (smp_data_o),
    .chan_o (smp_chan_o),
    .vld_o  (smp_vld_o)
  );
endmodule

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
  localparam int W    = 8;
  localparam int HALF = 4;
  localparam int MAXS = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [W-1:0] smp_data;
  logic smp_chan, smp_vld;

  always #10 clk = ~clk;

  serial_audio_rx #(.SAMPLE_W(W), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .aud_sck_i(sck), .aud_ws_i(ws), .aud_sd_i(sd),
    .smp_data_o(smp_data), .smp_chan_o(smp_chan), .smp_vld_o(smp_vld)
  );

  int n_chk = 0, n_err = 0;
  logic [W-1:0] exp_data [256];
  logic         exp_chan [256];
  int           exp_len  [256];
  int exp_n = 0, got_n = 0, hold_err = 0;
  logic         bit_a [MAXS];
  logic         ch_a  [MAXS];
  int n_slot;
  logic [W-1:0] prev_data;
  logic         prev_chan;

  function automatic logic [W-1:0] align(input logic [15:0] v, input int len);
    if (len <= W) return W'(v << (W - len));
    return W'(v >> (len - W));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!smp_vld && (smp_data !== prev_data || smp_chan !== prev_chan)) hold_err++; // R8
      if (smp_vld) begin
        if (got_n >= exp_n) begin
          check("R7 unexpected strobe", 16'(got_n), 16'(exp_n));
        end else begin
          if (exp_len[got_n] < W)      check("R4 zero fill", 16'(smp_data), 16'(exp_data[got_n]));
          else if (exp_len[got_n] > W) check("R5 truncate", 16'(smp_data), 16'(exp_data[got_n]));
          else                         check("R6 exact", 16'(smp_data), 16'(exp_data[got_n]));
          check("R3 channel", 16'(smp_chan), 16'(exp_chan[got_n]));
        end
        got_n++;
      end
    end
    prev_data = smp_data;
    prev_chan = smp_chan;
  end

  task automatic add_word(input logic [15:0] v, input int len, input logic ch, input logic expect_it);
    for (int b = len - 1; b >= 0; b--) begin
      bit_a[n_slot] = v[b];
      ch_a[n_slot]  = ch;
      n_slot++;
    end
    if (expect_it) begin
      exp_data[exp_n] = align(v, len);
      exp_chan[exp_n] = ch;
      exp_len[exp_n]  = len;
      exp_n++;
    end
  endtask

  // ws leads data by one slot (R2)
  task automatic play(input int upto);
    for (int s = 0; s < upto; s++) begin
      @(negedge clk);
      sck = 1'b0;
      sd  = bit_a[s];
      ws  = (s + 1 < n_slot) ? ch_a[s+1] : ch_a[s];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset vld", 16'(smp_vld), 16'h0);
    check("R1 reset data", 16'(smp_data), 16'h0);
    check("R1 reset chan", 16'(smp_chan), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release vld", 16'(smp_vld), 16'h0);
  endtask

  initial begin
    logic ch;
    int lens2 [3];
    repeat (3) @(negedge clk);
    check("R1 reset vld", 16'(smp_vld), 16'h0);
    check("R1 reset data", 16'(smp_data), 16'h0);
    rst_n = 1'b1;

    // group 1: sweep sender lengths 1..12, preamble on left is discarded (R7)
    n_slot = 0;
    add_word(16'h1f, 5, 1'b0, 1'b0);
    ch = 1'b1;
    for (int len = 1; len <= 12; len++) begin
      logic [15:0] m;
      m = 16'((32'h1 << len) - 1);
      add_word(m, len, ch, 1'b1);                           ch = ~ch;
      add_word(16'(1 << (len - 1)), len, ch, 1'b1);          ch = ~ch;
      add_word(16'h1, len, ch, 1'b1);                       ch = ~ch;
      add_word(16'(len * 37 + 91) & m, len, ch, 1'b1);     ch = ~ch;
    end
    add_word(16'h5, 6, ch, 1'b0);  // partial word, cut by reset (R7)
    play(n_slot - 3);
    repeat (20) @(negedge clk);
    check("R3 strobe count group1", 16'(got_n), 16'(exp_n));
    pulse_reset();

    // group 2: right-channel preamble after mid-word reset
    n_slot = 0;
    add_word(16'h2a, 7, 1'b1, 1'b0);
    lens2[0] = 8; lens2[1] = 3; lens2[2] = 11;
    ch = 1'b0;
    for (int k = 0; k < 3; k++) begin
      add_word(16'h0a5 + 16'(k * 29), lens2[k], ch, 1'b1); ch = ~ch;
      add_word(16'h7ff, lens2[k], ch, 1'b1);                ch = ~ch;
    end
    add_word(16'h0, 4, ch, 1'b0);
    play(n_slot);
    repeat (20) @(negedge clk);
    check("R3 strobe count total", 16'(got_n), 16'(exp_n));
    check("R8 output held between strobes", 16'(hold_err), 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule